// File: doc/BRIEF.md
# Framed Command Packet Receiver

This block turns a byte stream from a host link into checked command packets. A packet opens with a fixed four-byte header: a start marker, a command code, a payload length and a CRC over those three bytes. The header is followed by as many payload bytes as the length field gives, and then by a CRC over the payload. The header and the payload are checked separately. A failed header CRC ends the packet at once, before any payload byte is taken.

Payload bytes are written unchanged into an internal byte buffer. A downstream command executor reads them through an asynchronous read port. When both CRCs match, the receiver raises `pkt_avail` and presents the command code and payload length. When either CRC fails, it raises `nack_req` so that the executor can send a not-acknowledge reply.

Either flag stays up until the executor pulses `ack`, and bytes that arrive in the meantime are discarded. If the link goes silent in the middle of a packet, an inter-byte timeout returns the receiver to waiting for a header without raising any flag.

Top module: `cmd_pkt_receiver`

## Requirements
- R1: While waiting for a header, the receiver ignores every byte other than the start marker 0xA5. A packet can only begin with that byte.
- R2: The header bytes arrive in the order start marker, command code, length. A length byte above 64 abandons the packet silently: no flag is raised and the receiver waits for a new 0xA5.
- R3: The header CRC is CRC-8 with polynomial 0x07 and initial value 0x00. It is processed MSB-first over the marker, command and length bytes, and arrives as the fourth byte. On a mismatch, `nack_req` is high in the cycle after that byte is accepted, and no payload byte is taken.
- R4: Exactly as many payload bytes as the length field gives are stored unchanged, the first at `rd_addr` 0. `pay_len` reports that length.
- R5: The payload CRC uses the same CRC-8 restarted at 0x00 and covers the payload bytes only. It arrives after the last payload byte. A mismatch raises `nack_req` in the next cycle.
- R6: `pkt_avail` rises in the cycle after the final CRC byte is accepted, and only when both CRCs match. `cmd_code` then holds the command byte. With a length of 0 there is no payload phase, so the header CRC is the final byte.
- R7: `pkt_avail` and `nack_req` are never high together. Each one holds until an `ack` pulse and is low in the cycle after that pulse.
- R8: Bytes that arrive while either flag is high are dropped. They change neither the stored packet nor the receiver's state.
- R9: Once a packet has started, 1024 consecutive cycles without a byte return the receiver to waiting for a header, with no flag raised. Shorter gaps leave the packet intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is present on `in_data` this cycle |
| in_data | input | 8 | Received byte |
| ack | input | 1 | Executor has consumed the pending flag |
| cmd_code | output | 8 | Command code of the last accepted header |
| pay_len | output | 7 | Payload length of the last accepted header |
| rd_addr | input | 6 | Payload buffer read address |
| rd_data | output | 8 | Payload byte at `rd_addr` |
| pkt_avail | output | 1 | A valid, complete packet is waiting |
| nack_req | output | 1 | A CRC failure calls for a not-acknowledge reply |

## Verification
Good packets with lengths of 0, a few bytes and the maximum of 64 separate correct length handling from off-by-one errors in the payload counter and the buffer addressing. A corrupted header CRC and a corrupted payload CRC each have to yield a not-acknowledge. Leading garbage bytes and an out-of-range length test that header-structure failures stay silent. Three timing cases complete the set: a 1000-cycle gap inside the payload must be tolerated, a 1100-cycle stall must be abandoned silently, and a whole packet sent while a flag is held must be dropped without touching the stored result.

// File: rtl/pkt_rx_pkg.sv
// Shared types and the CRC-8 step function for the command packet receiver.
// Assumes byte-wide data and an MSB-first, non-reflected CRC.
package pkt_rx_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_SOF,
        ST_CMD,
        ST_SIZE,
        ST_HDR_CRC,
        ST_BODY,
        ST_BODY_CRC,
        ST_READY,
        ST_REJECT
    } rx_state_t;

    // Absorb one byte into a CRC-8 remainder, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                             input logic [7:0] data,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc ^ data;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/pkt_crc8.sv
// Running CRC-8 register, one byte per clock.
// clear zeroes the remainder, seed restarts it from zero with the current
// byte absorbed, and en absorbs the current byte. clear outranks seed,
// and seed outranks en.
module pkt_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       seed,
    input  logic       en,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import pkt_rx_pkg::*;

    // Holds the remainder across the bytes of a header or a payload.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= 8'h00;
        else if (seed)       crc <= crc8_step(8'h00, din, POLY);
        else if (en)         crc <= crc8_step(crc, din, POLY);
    end

endmodule

// File: rtl/pkt_payload_buf.sv
// Payload byte store with one synchronous write port and an asynchronous
// read port. Assumes the writer keeps waddr below DEPTH.
module pkt_payload_buf #(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Captures each payload byte as it is accepted.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read without latency. Addresses past DEPTH return zero.
    always_comb begin
        rdata = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
    end

    AST_WADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH)); // R4

endmodule

// File: rtl/pkt_byte_timer.sv
// Inter-byte silence timer. While run is high it counts cycles without a
// kick. expire is high in the cycle that completes LIMIT silent cycles.
// Assumes LIMIT >= 2.
module pkt_byte_timer #(
    parameter int LIMIT = 1024,
    localparam int CW   = $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expire
);
    logic [CW-1:0] cnt;

    // Counts silent cycles and saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || kick) cnt <= '0;
        else if (cnt != CW'(LIMIT - 1)) cnt <= cnt + 1'b1;
    end

    // Fires only when no byte arrives in the final silent cycle.
    always_comb begin
        expire = run && !kick && (cnt == CW'(LIMIT - 1));
    end

endmodule

// File: rtl/cmd_pkt_receiver.sv
// Framed command packet receiver. Collects a four-byte header (marker,
// command, length, CRC), then the payload and its CRC. It stores the
// payload and flags the result as available or as needing a
// not-acknowledge. Assumes MAX_PAYLOAD <= 255 and one byte per valid cycle.
module cmd_pkt_receiver #(
    parameter int          MAX_PAYLOAD    = 64,
    parameter int          TIMEOUT_CYCLES = 1024,
    parameter logic [7:0]  SOF            = 8'hA5,
    parameter logic [7:0]  POLY           = 8'h07,
    localparam int         AW             = $clog2(MAX_PAYLOAD),
    localparam int         LW             = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          ack,
    output logic [7:0]    cmd_code,
    output logic [LW-1:0] pay_len,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          pkt_avail,
    output logic          nack_req
);
    import pkt_rx_pkg::*;

    rx_state_t     state, nxt;
    logic [LW-1:0] idx_q;
    logic [7:0]    crc_val;
    logic          crc_clear, crc_seed, crc_en, buf_we;
    logic          mid_pkt, expire, size_ok;

    pkt_crc8 #(.POLY(POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .clear(crc_clear), .seed(crc_seed),
        .en(crc_en), .din(in_data), .crc(crc_val)
    );

    pkt_payload_buf #(.DEPTH(MAX_PAYLOAD)) u_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .waddr(idx_q[AW-1:0]),
        .wdata(in_data), .raddr(rd_addr), .rdata(rd_data)
    );

    pkt_byte_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(mid_pkt), .kick(in_valid),
        .expire(expire)
    );

    // Marks the states in which a packet is partly received.
    always_comb begin
        mid_pkt = (state != ST_WAIT_SOF) && (state != ST_READY) && (state != ST_REJECT);
        size_ok = (in_data <= 8'(MAX_PAYLOAD));
    end

    // Next-state and datapath control for one received byte.
    always_comb begin
        nxt       = state;
        crc_clear = 1'b0;
        crc_seed  = 1'b0;
        crc_en    = 1'b0;
        buf_we    = 1'b0;
        case (state)
            ST_WAIT_SOF: if (in_valid && in_data == SOF) begin
                crc_seed = 1'b1;
                nxt      = ST_CMD;
            end
            ST_CMD: if (in_valid) begin
                crc_en = 1'b1;
                nxt    = ST_SIZE;
            end
            ST_SIZE: if (in_valid) begin
                if (size_ok) begin
                    crc_en = 1'b1;
                    nxt    = ST_HDR_CRC;
                end else begin
                    nxt = ST_WAIT_SOF;
                end
            end
            ST_HDR_CRC: if (in_valid) begin
                crc_clear = 1'b1;
                if (in_data != crc_val)   nxt = ST_REJECT;
                else if (pay_len == '0)   nxt = ST_READY;
                else                      nxt = ST_BODY;
            end
            ST_BODY: if (in_valid) begin
                buf_we = 1'b1;
                crc_en = 1'b1;
                if (idx_q == pay_len - LW'(1)) nxt = ST_BODY_CRC;
            end
            ST_BODY_CRC: if (in_valid) begin
                nxt = (in_data == crc_val) ? ST_READY : ST_REJECT;
            end
            ST_READY, ST_REJECT: if (ack) nxt = ST_WAIT_SOF;
            default: nxt = ST_WAIT_SOF;
        endcase
        if (mid_pkt && expire) nxt = ST_WAIT_SOF;
    end

    // State register and header fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_WAIT_SOF;
            cmd_code <= 8'h00;
            pay_len  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_CMD && in_valid) cmd_code <= in_data;
            if (state == ST_SIZE && in_valid && size_ok) pay_len <= in_data[LW-1:0];
        end
    end

    // Payload write index, restarted at each header CRC byte.
    always_ff @(posedge clk) begin
        if (!rst_n || (state == ST_HDR_CRC && in_valid)) idx_q <= '0;
        else if (buf_we)                                 idx_q <= idx_q + 1'b1;
    end

    // Flags decoded from the holding states.
    always_comb begin
        pkt_avail = (state == ST_READY);
        nack_req  = (state == ST_REJECT);
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_avail && nack_req)); // R7
    AST_AVAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_avail && !ack) |=> pkt_avail); // R7
    AST_NACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_req && !ack) |=> nack_req); // R7
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ((pkt_avail || nack_req) && ack) |=> (!pkt_avail && !nack_req)); // R7
    AST_NO_STORE_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_avail || nack_req) |-> !buf_we); // R8
    AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pay_len) <= MAX_PAYLOAD); // R2
    AST_FLAG_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pkt_avail) || $rose(nack_req)) |-> $past(in_valid)); // R6
    AST_TIMEOUT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!pkt_avail && !nack_req)); // R9

endmodule

// File: tb/test_cmd_pkt_receiver.sv
`timescale 1ns/100ps
module test_cmd_pkt_receiver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       ack = 1'b0;
    logic [7:0] cmd_code;
    logic [6:0] pay_len;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pkt_avail, nack_req;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  hold_ack = 1'b0;

    bit         exp_nack[$];
    logic [7:0] exp_cmd[$];
    int         exp_len[$];
    logic [7:0] exp_pay[$];

    always #2.5 clk = ~clk;

    cmd_pkt_receiver i_cmd_pkt_receiver (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .ack(ack), .cmd_code(cmd_code), .pay_len(pay_len), .rd_addr(rd_addr),
        .rd_data(rd_data), .pkt_avail(pkt_avail), .nack_req(nack_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Reference CRC-8, poly 0x07, shifting one bit at a time.
    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[7] ^ d[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_drain(input string req);
        int n = 0;
        while ((exp_nack.size() != 0 || pkt_avail || nack_req) && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(n < 400, req, n, 0);
    endtask

    // Drives one packet; pushes the expected outcome first.
    task automatic send_pkt(input logic [7:0] cmd, input int len, input logic [7:0] seed,
                            input bit bad_h, input bit bad_p, input int gap,
                            input bit do_wait, input bit expect_it, input string req);
        logic [7:0] hc, pc, b;
        hc = ref_crc(ref_crc(ref_crc(8'h00, 8'hA5), cmd), 8'(len));
        if (bad_h) hc = hc ^ 8'h01;
        if (expect_it) begin
            exp_nack.push_back(bad_h || bad_p);
            exp_cmd.push_back(cmd);
            exp_len.push_back(len);
            if (!(bad_h || bad_p))
                for (int i = 0; i < len; i++) exp_pay.push_back(8'(seed + 8'(i * 13)));
        end
        send_byte(8'hA5);
        send_byte(cmd);
        send_byte(8'(len));
        send_byte(hc);
        if (!bad_h && len > 0) begin
            pc = 8'h00;
            for (int i = 0; i < len; i++) begin
                b  = 8'(seed + 8'(i * 13));
                pc = ref_crc(pc, b);
                send_byte(b);
                if (i == 0 && gap > 0) repeat (gap) @(negedge clk);
            end
            if (bad_p) pc = pc ^ 8'h10;
            send_byte(pc);
        end
        if (expect_it) begin
            chk(pkt_avail == !(bad_h || bad_p), {req, " avail timing"}, pkt_avail, !(bad_h || bad_p));
            chk(nack_req == (bad_h || bad_p), {req, " nack timing"}, nack_req, (bad_h || bad_p));
        end
        if (do_wait) wait_drain({req, " drain"});
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        bit seen = 1'b0;
        repeat (cycles) begin
            @(negedge clk);
            if (pkt_avail || nack_req) seen = 1'b1;
        end
        chk(!seen, req, seen, 0);
    endtask

    // Monitor: pops expected items and compares them as the flags appear.
    initial begin
        bit         en;
        logic [7:0] ec, eb;
        int         el;
        forever begin
            @(negedge clk);
            if ((pkt_avail || nack_req) && !hold_ack) begin
                if (exp_nack.size() == 0) begin
                    chk(1'b0, "R8 unexpected flag", {pkt_avail, nack_req}, 0);
                end else begin
                    en = exp_nack.pop_front();
                    ec = exp_cmd.pop_front();
                    el = exp_len.pop_front();
                    chk(nack_req == en, "R3 R5 outcome nack", nack_req, en);
                    chk(pkt_avail == !en, "R6 outcome avail", pkt_avail, !en);
                    if (!en) begin
                        chk(cmd_code == ec, "R6 command code", cmd_code, ec);
                        chk(int'(pay_len) == el, "R4 length", pay_len, el);
                        for (int i = 0; i < el; i++) begin
                            rd_addr = 6'(i);
                            #0.5;
                            eb = exp_pay.pop_front();
                            chk(rd_data == eb, "R4 payload byte", rd_data, eb);
                        end
                    end
                end
                @(negedge clk);
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
                chk(!pkt_avail && !nack_req, "R7 release after ack", {pkt_avail, nack_req}, 0);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Driver sequence.
    initial begin
        repeat (4) @(negedge clk);
        chk(!pkt_avail && !nack_req, "reset flags low", {pkt_avail, nack_req}, 0);
        chk(cmd_code == 8'h00, "reset command code", cmd_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: basic good packet
        send_pkt(8'h21, 3, 8'h10, 0, 0, 0, 1, 1, "R6 basic");
        // R6: zero length, header CRC is the last byte
        send_pkt(8'h07, 0, 8'h00, 0, 0, 0, 1, 1, "R6 zero length");
        // R4: maximum length
        send_pkt(8'h3C, 64, 8'h5A, 0, 0, 0, 1, 1, "R4 max length");
        // R3: corrupted header CRC, nack right after the fourth byte
        send_pkt(8'h44, 5, 8'h01, 1, 0, 0, 1, 1, "R3 header crc");
        // R5: corrupted payload CRC
        send_pkt(8'h45, 4, 8'h77, 0, 1, 0, 1, 1, "R5 payload crc");

        // R1: garbage before the marker is ignored
        send_byte(8'h00); send_byte(8'h5A); send_byte(8'hFF); send_byte(8'h13);
        expect_quiet(5, "R1 garbage quiet");
        send_pkt(8'h66, 2, 8'h33, 0, 0, 0, 1, 1, "R1 after garbage");

        // R2: out-of-range length abandons silently
        send_byte(8'hA5); send_byte(8'h12); send_byte(8'd65);
        expect_quiet(5, "R2 length 65 quiet");
        send_pkt(8'h67, 1, 8'h90, 0, 0, 0, 1, 1, "R2 after bad length");

        // R9: stall beyond the timeout returns to header wait silently
        send_byte(8'hA5); send_byte(8'h11); send_byte(8'd2);
        expect_quiet(1100, "R9 stall quiet");
        send_pkt(8'h68, 2, 8'h44, 0, 0, 0, 1, 1, "R9 after timeout");
        // R9: a gap shorter than the timeout keeps the packet
        send_pkt(8'h69, 3, 8'h0F, 0, 0, 1000, 1, 1, "R9 short gap");

        // R8: a packet sent while a flag is held is dropped
        hold_ack = 1'b1;
        send_pkt(8'h70, 3, 8'h21, 0, 0, 0, 0, 1, "R8 first");
        send_pkt(8'h71, 2, 8'hC0, 0, 0, 0, 0, 0, "R8 dropped");
        chk(pkt_avail && cmd_code == 8'h70, "R8 held result kept", cmd_code, 8'h70);
        hold_ack = 1'b0;
        wait_drain("R8 drain");
        expect_quiet(20, "R8 dropped packet never surfaces");

        // R7: ack with nothing pending has no effect
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        send_pkt(8'h72, 1, 8'h08, 0, 0, 0, 1, 1, "R7 stray ack");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule